// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block is the control sequencer of one DMA channel whose work is described by a linked list of descriptors in memory. When software has armed the channel, enabled it and left it unpaused, each run request makes the sequencer choose a descriptor address, issue a fetch request for it, and wait for a verdict from a separate checker. The checker returns either an error code or the decoded descriptor fields. The address is either the programmed start address or the next-descriptor pointer saved from the previous descriptor.

An accepted descriptor in contiguous mode becomes a series of line read requests. Each read has the descriptor's line length, and each line starts a stride of sixteen-byte units after the previous one. Once the payload is issued, the sequencer can request a writeback of the descriptor to its own address and can pulse a completion event. It then follows the next pointer unless the descriptor ends the chain, the channel runs in single-descriptor mode, or the channel is no longer allowed to run. A sticky finished flag records whether the chain ended, so the next run restarts at the start address. A self-clearing retrigger request forces a restart from the start address.

Top module: `desc_chain_seq`

## Requirements
- R1: During and after reset every request output and event output is low and the finished flag is set, so the first run fetches from `start_addr`.
- R2: A run begins only on a `run_req` pulse while the trigger is armed, the channel is enabled and the channel is not paused. Otherwise `run_req` has no effect.
- R3: A `ctrl_wr` pulse loads the enable and pause bits and disarms the trigger. A `trig_set` pulse arms it, and it wins over `ctrl_wr` in the same cycle.
- R4: The fetch address is `start_addr` when the finished flag is set or a retrigger is pending. Otherwise it is the next pointer of the last accepted descriptor.
- R5: A pending retrigger is cleared whenever a descriptor address is chosen. A later choice without a new `retrig_set` follows the chain again.
- R6: Within a run the sequencer fetches descriptor after descriptor through their next pointers. It stops after a descriptor flagged last (`vd_last`) or end-of-frame (`vd_frame_end`), and it sets the finished flag.
- R7: A nonzero verdict code (1 bus fault, 2 bad format, 3 bad checksum, 4 already done; 0 means accepted) gives a one-cycle `err_evt` with `err_kind` equal to the code. It also sets the finished flag, and no line read, writeback or further fetch follows in that run.
- R8: For a contiguous descriptor (`vd_frag`=0) with nonzero size and line length, the sequencer issues ceil(size/line) reads. Read k is at `vd_src` + k*`vd_stride`*16 with length `vd_line`. A fragmented descriptor, a zero size or a zero line length issues no reads.
- R9: When `vd_update` is set, a writeback request to the descriptor's own fetch address follows the payload. When it is clear, no writeback is requested.
- R10: When `vd_irq` is set, `done_evt` pulses for exactly one cycle once the descriptor is finished. When it is clear, there is no pulse.
- R11: With `single_mode` high, a run handles one descriptor and stops. The next run continues at that descriptor's next pointer.
- R12: If the channel is paused or disarmed while a descriptor is in progress, the sequencer goes idle after that descriptor and keeps the next pointer. The next run after re-enabling continues there.
- R13: At most one request is asserted at a time. A request holds, with a stable address, until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req | input | 1 | Pulse asking for a run |
| trig_set | input | 1 | Pulse arming the trigger |
| retrig_set | input | 1 | Pulse requesting a restart from the start address |
| ctrl_wr | input | 1 | Pulse writing enable and pause; disarms the trigger |
| ctrl_en | input | 1 | Enable value for `ctrl_wr` |
| ctrl_pause | input | 1 | Pause value for `ctrl_wr` |
| single_mode | input | 1 | One descriptor per run |
| start_addr | input | ADDR_W | First descriptor address of the chain |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | ADDR_W | Descriptor address to fetch |
| fetch_ack | input | 1 | Fetch accepted |
| vd_valid | input | 1 | Verdict and fields valid |
| vd_code | input | 3 | Verdict code, 0 accepted |
| vd_next | input | ADDR_W | Next descriptor pointer |
| vd_src | input | ADDR_W | Payload source address |
| vd_size | input | SIZE_W | Payload size in bytes |
| vd_line | input | 18 | Line length in bytes |
| vd_stride | input | 14 | Line stride in 16-byte units |
| vd_last | input | 1 | Last descriptor of the chain |
| vd_frame_end | input | 1 | Last descriptor of the frame |
| vd_frag | input | 1 | Fragmented mode, no line reads |
| vd_update | input | 1 | Writeback requested |
| vd_irq | input | 1 | Completion event requested |
| rd_req | output | 1 | Line read request |
| rd_addr | output | ADDR_W | Line read address |
| rd_len | output | 18 | Line read length |
| rd_ack | input | 1 | Line read accepted |
| wb_req | output | 1 | Descriptor writeback request |
| wb_addr | output | ADDR_W | Writeback address |
| wb_ack | input | 1 | Writeback accepted |
| done_evt | output | 1 | Completion pulse |
| err_evt | output | 1 | Error pulse |
| err_kind | output | 3 | Verdict code of the last error |

## Verification
Corrupt internal state shows up at the ports on the next fetch. A stale finished flag or an uncleared retrigger gives a wrong `fetch_addr` within a few cycles of the following `run_req`, so every fetch address in the chain, restart, retrigger and resume sequences is compared with the value the bench expects. A wrong line remainder or stride shows up as a bad `rd_addr` or a wrong read count before the descriptor completes. A wrong arm, enable or pause bit shows up as a fetch that appears, or fails to appear, within a short idle window after `run_req`.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
    localparam int LINE_W       = 18;
    localparam int STRIDE_W     = 14;
    localparam int STRIDE_SHIFT = 4;
    localparam int CODE_W       = 3;

    typedef enum logic [CODE_W-1:0] {
        VERD_OK    = 3'd0,
        VERD_BUS   = 3'd1,
        VERD_FORM  = 3'd2,
        VERD_SUM   = 3'd3,
        VERD_STALE = 3'd4
    } verdict_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAITV,
        S_LINES,
        S_WBACK,
        S_POST,
        S_FAULT
    } seq_state_e;

    typedef struct packed {
        logic chain_end;
        logic wb_en;
        logic irq_en;
    } desc_flags_t;

    function automatic logic wants_lines(input logic frag, input logic size_nz,
                                         input logic line_nz);
        return !frag && size_nz && line_nz;
    endfunction
endpackage

// File: rtl/dcs_arm_ctl.sv
`timescale 1ns/1ps
module dcs_arm_ctl (
    input  logic clk,
    input  logic rst,
    input  logic trig_set,
    input  logic retrig_set,
    input  logic ctrl_wr,
    input  logic ctrl_en,
    input  logic ctrl_pause,
    input  logic consume,
    output logic go_ok,
    output logic retrig_pend
);
    logic armed_q, en_q, pause_q, retrig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            en_q     <= 1'b0;
            pause_q  <= 1'b0;
            retrig_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q    <= ctrl_en;
                pause_q <= ctrl_pause;
            end
            if (trig_set)      armed_q <= 1'b1;
            else if (ctrl_wr)  armed_q <= 1'b0;
            if (retrig_set)    retrig_q <= 1'b1;
            else if (consume)  retrig_q <= 1'b0;
        end
    end

    assign go_ok       = armed_q && en_q && !pause_q;
    assign retrig_pend = retrig_q;

    // R3: a control write without a trigger leaves the channel unable to run
    p_disarm_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !trig_set) |=> !go_ok);
endmodule

// File: rtl/dcs_line_walker.sv
`timescale 1ns/1ps
module dcs_line_walker #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [ADDR_W-1:0]           src,
    input  logic [SIZE_W-1:0]           size,
    input  logic [dcs_pkg::LINE_W-1:0]  line,
    input  logic [dcs_pkg::STRIDE_W-1:0] stride,
    input  logic                        step,
    output logic [ADDR_W-1:0]           addr,
    output logic [dcs_pkg::LINE_W-1:0]  len,
    output logic                        last_line
);
    import dcs_pkg::*;
    localparam int STEP_W = STRIDE_W + STRIDE_SHIFT;

    logic [ADDR_W-1:0]   addr_q;
    logic [SIZE_W-1:0]   remain_q;
    logic [LINE_W-1:0]   line_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [SIZE_W-1:0]   line_ext;
    logic [STEP_W-1:0]   step_bytes;

    assign line_ext   = SIZE_W'(line_q);
    assign step_bytes = {stride_q, {STRIDE_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= '0;
            line_q   <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr_q   <= src;
            remain_q <= size;
            line_q   <= line;
            stride_q <= stride;
        end else if (step) begin
            addr_q   <= addr_q + ADDR_W'(step_bytes);
            remain_q <= (remain_q > line_ext) ? remain_q - line_ext : '0;
        end
    end

    assign addr      = addr_q;
    assign len       = line_q;
    assign last_line = (remain_q <= line_ext);
endmodule

// File: rtl/desc_chain_seq.sv
`timescale 1ns/1ps
module desc_chain_seq #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          run_req,
    input  logic                          trig_set,
    input  logic                          retrig_set,
    input  logic                          ctrl_wr,
    input  logic                          ctrl_en,
    input  logic                          ctrl_pause,
    input  logic                          single_mode,
    input  logic [ADDR_W-1:0]             start_addr,
    output logic                          fetch_req,
    output logic [ADDR_W-1:0]             fetch_addr,
    input  logic                          fetch_ack,
    input  logic                          vd_valid,
    input  logic [2:0]                    vd_code,
    input  logic [ADDR_W-1:0]             vd_next,
    input  logic [ADDR_W-1:0]             vd_src,
    input  logic [SIZE_W-1:0]             vd_size,
    input  logic [17:0]                   vd_line,
    input  logic [13:0]                   vd_stride,
    input  logic                          vd_last,
    input  logic                          vd_frame_end,
    input  logic                          vd_frag,
    input  logic                          vd_update,
    input  logic                          vd_irq,
    output logic                          rd_req,
    output logic [ADDR_W-1:0]             rd_addr,
    output logic [17:0]                   rd_len,
    input  logic                          rd_ack,
    output logic                          wb_req,
    output logic [ADDR_W-1:0]             wb_addr,
    input  logic                          wb_ack,
    output logic                          done_evt,
    output logic                          err_evt,
    output logic [2:0]                    err_kind
);
    import dcs_pkg::*;

    seq_state_e          state_q, state_d;
    logic [ADDR_W-1:0]   cur_addr_q, next_addr_q;
    logic                finished_q;
    desc_flags_t         flags_q;
    logic [CODE_W-1:0]   err_q;

    logic go_ok, retrig_pend, start_now, from_start;
    logic verdict_ok, verdict_bad, payload, walk_load, walk_step, walk_last;

    dcs_arm_ctl u_arm (
        .clk        (clk),
        .rst        (rst),
        .trig_set   (trig_set),
        .retrig_set (retrig_set),
        .ctrl_wr    (ctrl_wr),
        .ctrl_en    (ctrl_en),
        .ctrl_pause (ctrl_pause),
        .consume    (start_now),
        .go_ok      (go_ok),
        .retrig_pend(retrig_pend)
    );

    dcs_line_walker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (walk_load),
        .src       (vd_src),
        .size      (vd_size),
        .line      (vd_line),
        .stride    (vd_stride),
        .step      (walk_step),
        .addr      (rd_addr),
        .len       (rd_len),
        .last_line (walk_last)
    );

    assign verdict_ok  = (state_q == S_WAITV) && vd_valid && (vd_code == VERD_OK);
    assign verdict_bad = (state_q == S_WAITV) && vd_valid && (vd_code != VERD_OK);
    assign payload     = wants_lines(vd_frag, vd_size != '0, vd_line != '0);
    assign walk_load   = verdict_ok;
    assign walk_step   = (state_q == S_LINES) && rd_ack;
    assign from_start  = finished_q || retrig_pend;

    always_comb begin
        start_now = 1'b0;
        if (state_q == S_IDLE)
            start_now = run_req && go_ok;
        else if (state_q == S_POST)
            start_now = !flags_q.chain_end && !single_mode && go_ok;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (start_now) state_d = S_FETCH;
            S_FETCH: if (fetch_ack) state_d = S_WAITV;
            S_WAITV: begin
                if (verdict_bad)               state_d = S_FAULT;
                else if (verdict_ok) begin
                    if (payload)               state_d = S_LINES;
                    else if (vd_update)        state_d = S_WBACK;
                    else                       state_d = S_POST;
                end
            end
            S_LINES: if (rd_ack && walk_last)
                         state_d = flags_q.wb_en ? S_WBACK : S_POST;
            S_WBACK: if (wb_ack) state_d = S_POST;
            S_POST:  state_d = start_now ? S_FETCH : S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            cur_addr_q  <= '0;
            next_addr_q <= '0;
            finished_q  <= 1'b1;
            flags_q     <= '0;
            err_q       <= '0;
        end else begin
            state_q <= state_d;
            if (start_now) begin
                cur_addr_q <= from_start ? start_addr : next_addr_q;
                finished_q <= 1'b0;
            end
            if (verdict_bad) begin
                finished_q <= 1'b1;
                err_q      <= vd_code;
            end
            if (verdict_ok) begin
                next_addr_q <= vd_next;
                flags_q     <= '{chain_end: vd_last || vd_frame_end,
                                 wb_en:     vd_update,
                                 irq_en:    vd_irq};
                finished_q  <= vd_last || vd_frame_end;
            end
        end
    end

    assign fetch_req  = (state_q == S_FETCH);
    assign fetch_addr = cur_addr_q;
    assign rd_req     = (state_q == S_LINES);
    assign wb_req     = (state_q == S_WBACK);
    assign wb_addr    = cur_addr_q;
    assign done_evt   = (state_q == S_POST) && flags_q.irq_en;
    assign err_evt    = (state_q == S_FAULT);
    assign err_kind   = err_q;

    // R13: requests hold with a stable address until acknowledged
    p_fetch_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
    p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_len)));
    p_wb_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));
    p_one_req_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_req, rd_req, wb_req}));
    // R2: a fetch only starts when the channel was allowed to run
    p_gated_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_req) |-> $past(go_ok));
    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !done_evt);
    // R7: an error ends the run with nothing requested next
    p_err_stop_r7: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> (!fetch_req && !rd_req && !wb_req && !err_evt));
endmodule

// File: tb/sim_desc_chain_seq.sv
`timescale 1ns/1ps
module sim_desc_chain_seq;
    localparam int AW = 32;
    localparam int SW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_req = 0, trig_set = 0, retrig_set = 0, ctrl_wr = 0;
    logic ctrl_en = 0, ctrl_pause = 0, single_mode = 0;
    logic [AW-1:0] start_addr = 32'h0000_1000;
    logic fetch_req; logic [AW-1:0] fetch_addr; logic fetch_ack = 0;
    logic vd_valid = 0; logic [2:0] vd_code = 0;
    logic [AW-1:0] vd_next = 0, vd_src = 0; logic [SW-1:0] vd_size = 0;
    logic [17:0] vd_line = 0; logic [13:0] vd_stride = 0;
    logic vd_last = 0, vd_frame_end = 0, vd_frag = 0, vd_update = 0, vd_irq = 0;
    logic rd_req; logic [AW-1:0] rd_addr; logic [17:0] rd_len; logic rd_ack = 0;
    logic wb_req; logic [AW-1:0] wb_addr; logic wb_ack = 0;
    logic done_evt, err_evt; logic [2:0] err_kind;

    int n_chk = 0, n_err = 0, n_done = 0, n_fault = 0;
    logic [2:0] last_kind = 0;

    always #2.5 clk = ~clk;

    desc_chain_seq #(.ADDR_W(AW), .SIZE_W(SW)) u0 (
        .clk(clk), .rst(rst), .run_req(run_req), .trig_set(trig_set),
        .retrig_set(retrig_set), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
        .ctrl_pause(ctrl_pause), .single_mode(single_mode), .start_addr(start_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
        .vd_valid(vd_valid), .vd_code(vd_code), .vd_next(vd_next), .vd_src(vd_src),
        .vd_size(vd_size), .vd_line(vd_line), .vd_stride(vd_stride), .vd_last(vd_last),
        .vd_frame_end(vd_frame_end), .vd_frag(vd_frag), .vd_update(vd_update),
        .vd_irq(vd_irq), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_ack(rd_ack), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .done_evt(done_evt), .err_evt(err_evt), .err_kind(err_kind)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (done_evt) n_done++;
            if (err_evt) begin n_fault++; last_kind = err_kind; end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_run();
        run_req = 1; @(negedge clk); run_req = 0;
    endtask

    task automatic ctrl(input logic en, input logic pause, input logic arm);
        ctrl_wr = 1; ctrl_en = en; ctrl_pause = pause; trig_set = arm;
        @(negedge clk);
        ctrl_wr = 0; trig_set = 0;
    endtask

    task automatic arm();
        trig_set = 1; @(negedge clk); trig_set = 0;
    endtask

    task automatic set_desc(input logic [31:0] nxt, input logic [31:0] src,
                            input int size, input int line, input int stride,
                            input logic last, input logic fend, input logic frag,
                            input logic upd, input logic irq);
        vd_next = nxt; vd_src = src; vd_size = size; vd_line = line[17:0];
        vd_stride = stride[13:0]; vd_last = last; vd_frame_end = fend;
        vd_frag = frag; vd_update = upd; vd_irq = irq;
    endtask

    task automatic idle_check(input string req, input int cycles);
        logic seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (fetch_req) seen = 1;
        end
        chk(req, seen, 1'b0);
    endtask

    task automatic serve_head(input logic [31:0] exp_addr, input logic [2:0] code,
                              input string req);
        int t = 0;
        while (!fetch_req && t < 60) begin @(negedge clk); t++; end
        chk({req, " fetch seen"}, fetch_req, 1'b1);
        chk({req, " fetch addr"}, fetch_addr, exp_addr);
        @(negedge clk);
        chk("R13 fetch held", {fetch_req, fetch_addr}, {1'b1, exp_addr});
        fetch_ack = 1; @(negedge clk); fetch_ack = 0;
        vd_code = code; vd_valid = 1; @(negedge clk); vd_valid = 0;
    endtask

    task automatic serve_tail(input logic [31:0] exp_addr);
        int n;
        if (!vd_frag && vd_size != 0 && vd_line != 0) begin
            n = (int'(vd_size) + int'(vd_line) - 1) / int'(vd_line);
            for (int k = 0; k < n; k++) begin
                int t = 0;
                while (!rd_req && t < 40) begin @(negedge clk); t++; end
                chk("R8 read present", rd_req, 1'b1);
                chk("R8 read addr", rd_addr, vd_src + 32'(k * int'(vd_stride) * 16));
                chk("R8 read len", rd_len, vd_line);
                rd_ack = 1; @(negedge clk); rd_ack = 0;
            end
            chk("R8 no extra read", rd_req, 1'b0);
        end else begin
            chk("R8 no read", rd_req, 1'b0);
        end
        if (vd_update) begin
            int t = 0;
            while (!wb_req && t < 40) begin @(negedge clk); t++; end
            chk("R9 writeback present", wb_req, 1'b1);
            chk("R9 writeback addr", wb_addr, exp_addr);
            wb_ack = 1; @(negedge clk); wb_ack = 0;
        end else begin
            chk("R9 no writeback", wb_req, 1'b0);
        end
    endtask

    task automatic serve(input logic [31:0] exp_addr, input string req);
        serve_head(exp_addr, 3'd0, req);
        serve_tail(exp_addr);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        chk("R1 reset requests", {fetch_req, rd_req, wb_req, done_evt, err_evt}, 5'b0);
        rst = 0;
        @(negedge clk);
        chk("R1 idle after reset", {fetch_req, rd_req, wb_req}, 3'b0);

        // R2: nothing armed or enabled
        pulse_run(); idle_check("R2 no trigger", 8);
        ctrl(1, 0, 0);
        pulse_run(); idle_check("R3 enabled but not armed", 8);
        ctrl(0, 0, 1);
        pulse_run(); idle_check("R2 armed but disabled", 8);
        ctrl(1, 1, 1);
        pulse_run(); idle_check("R2 paused", 8);
        // R3: trigger and control write in the same cycle leave it armed
        ctrl(1, 0, 1);

        // Chain of three, R1 start, R6 follow pointers, R8 lines, R10 events
        d0 = n_done;
        pulse_run();
        set_desc(32'h2000, 32'h0004_0000, 100, 32, 5, 0, 0, 0, 1, 1);
        serve(32'h1000, "R1 first run");
        set_desc(32'h3000, 32'h0005_0000, 500, 64, 2, 0, 0, 1, 0, 0);
        serve(32'h2000, "R6 second");
        set_desc(32'h7700, 32'h0006_0100, 64, 64, 0, 1, 0, 0, 0, 1);
        serve(32'h3000, "R6 third");
        idle_check("R6 stop after last", 12);
        chk("R10 completion pulses", n_done - d0, 2);

        // R4: finished chain restarts at start; end-of-frame ends too
        pulse_run();
        set_desc(32'h4000, 32'h0, 0, 16, 1, 0, 1, 0, 0, 0);
        serve(32'h1000, "R4 restart");
        idle_check("R6 stop after frame end", 10);
        d0 = n_done;
        pulse_run();
        set_desc(32'h4100, 32'h0008_0000, 40, 0, 3, 1, 0, 0, 1, 0);
        serve(32'h1000, "R8 zero line");
        idle_check("R6 stop", 6);
        chk("R10 no pulse without flag", n_done - d0, 0);

        // R7: errors
        pulse_run();
        set_desc(32'h5000, 32'h0009_0000, 64, 16, 1, 0, 0, 0, 1, 1);
        serve_head(32'h1000, 3'd3, "R7 checksum");
        @(negedge clk);
        chk("R7 no read after error", {rd_req, wb_req}, 2'b0);
        idle_check("R7 run stopped", 6);
        chk("R7 error count", n_fault, 1);
        chk("R7 error kind", last_kind, 3'd3);
        pulse_run();
        serve_head(32'h1000, 3'd4, "R7 restart after error");
        idle_check("R7 stopped again", 6);
        chk("R7 stale kind", last_kind, 3'd4);

        // R11 single mode, R5 retrigger
        single_mode = 1;
        pulse_run();
        set_desc(32'h6000, 32'h000A_0000, 48, 16, 4, 0, 0, 0, 0, 0);
        serve(32'h1000, "R11 single first");
        idle_check("R11 one descriptor", 10);
        pulse_run();
        set_desc(32'h6800, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
        serve(32'h6000, "R11 continue at next");
        idle_check("R11 one descriptor again", 8);
        retrig_set = 1; @(negedge clk); retrig_set = 0;
        pulse_run();
        set_desc(32'h6C00, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
        serve(32'h1000, "R5 retrigger to start");
        idle_check("R11 hold", 6);
        pulse_run();
        set_desc(32'h0, 32'h0, 0, 0, 0, 1, 0, 0, 0, 0);
        serve(32'h6C00, "R5 retrigger consumed");
        single_mode = 0;
        idle_check("R6 end", 6);

        // R12 pause between descriptors
        pulse_run();
        set_desc(32'h8000, 32'h000B_0000, 96, 32, 8, 0, 0, 0, 0, 0);
        serve_head(32'h1000, 3'd0, "R12 before pause");
        ctrl(1, 1, 0);
        serve_tail(32'h1000);
        idle_check("R12 held by pause", 10);
        pulse_run(); idle_check("R12 run while paused", 6);
        ctrl(1, 0, 1);
        pulse_run();
        set_desc(32'h0, 32'h000C_0000, 20, 8, 1, 1, 0, 0, 1, 0);
        serve(32'h8000, "R12 resume at next");
        idle_check("R12 end", 6);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule